// File: doc/BRIEF.md
# Circular Trace Store with Pointer and Status Control

This block holds the entries of a circular trace store and manages its write and read pointers. A capture stage offers one entry per cycle. The block records the entry while there is room. When the store is full it drops the entry and remembers that a gap has opened. The next entry it records carries a discontinuity mark. A rising edge on the trace enable starts a new trace: both pointers return to slot 0 and every pending flag clears.

Software reads the store through a 64-bit register port. An entry is 69 bits wide: a 67-bit payload plus two status bits that are built at read time. Each entry is therefore returned by two consecutive reads, the low word first and then the high word. The read pointer moves only after the high word has been returned. Writes and reads share one storage port, and writes have priority. A read that collides with a write waits in a single pending slot and is served in the first cycle with no write.

An interrupt pulse reports that the occupancy, meaning the distance between the two pointers, has just reached a selected level.

Top module: `trace_ptr_unit`

## Requirements
- R1: A rising edge of `traceEn` empties the store and clears the pending discontinuity and the read-half state. A read that follows reports not-valid, even if entries were held before.
- R2: Each accepted write stores `wrData` at the write pointer, and entries are read back in the order they were written.
- R3: While the store holds DEPTH entries, further writes are dropped and held entries are not overwritten. Writing resumes as soon as a completed read frees a slot.
- R4: After one or more writes are dropped, the next accepted entry reads back with status 3 (valid, discontinuity). Later entries read back with status 1.
- R5: A read of an empty store does not move the read pointer, and its low word is zero. Its high word carries status 0, or status 2 if a dropped write is still pending. If the store was empty when the low word was read, the matching high word is also reported not-valid, even if a write arrived in between.
- R6: The low word is payload bits 63:0. In the high word, bits 2:0 are payload bits 66:64, bit 3 is the valid flag and bit 4 is the discontinuity flag. All other high-word bits are zero.
- R7: The first read of an entry returns the low word and the second returns the high word. The read pointer advances only after the second read, and only for a valid entry.
- R8: The storage port serves either one write or one read per cycle, and writes win. A read requested in a write cycle is served in the next cycle without a write. `rdValid` rises one cycle after the read is served.
- R9: `irq` pulses for one cycle when an accepted write makes the occupancy (write pointer minus read pointer) equal to the selected level. `thrSel` selects the level: 1 for DEPTH/2, 2 for 3·DEPTH/4, 3 for DEPTH, and 0 disables the interrupt.
- R10: While `traceEn` is low, write requests are ignored. Reads still drain the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| traceEn | input | 1 | Trace enable; a rising edge restarts the trace |
| wrReq | input | 1 | Capture-side write request |
| wrData | input | PAYLOAD_W (67) | Entry payload |
| rdReq | input | 1 | One-cycle register read request |
| rdData | output | REG_W (64) | Returned register word |
| rdValid | output | 1 | `rdData` holds the answer to a read |
| thrSel | input | 2 | Interrupt level select |
| irq | output | 1 | Level-reached interrupt pulse |

## Verification
The assertions assume that software issues one read at a time, so `rdReq` is not raised again until the previous `rdValid` has been seen. Under that assumption one pending slot is enough, and the one-cycle read latency after service always holds. The stimulus keeps to this because every read task waits for its answer before it returns. Write and read requests are changed only on the falling clock edge, so the pointer arithmetic always sees stable requests.

// File: rtl/trace_ptr_pkg.sv
package trace_ptr_pkg;

  // strobes from the control unit to the storage datapath
  typedef struct packed {
    logic wrEn;      // store wrData at wrAddr this cycle
    logic entryDisc; // discontinuity mark for a write; pending mark for a read
    logic rdEn;      // serve one register read this cycle
    logic rdHigh;    // the served read returns the high word
    logic rdHit;     // the served read refers to a valid entry
  } ctlStrobes_t;

  // interrupt level select encodings
  localparam logic [1:0] THR_OFF  = 2'd0;
  localparam logic [1:0] THR_HALF = 2'd1;
  localparam logic [1:0] THR_3Q   = 2'd2;
  localparam logic [1:0] THR_FULL = 2'd3;

endpackage

// File: rtl/trace_ptr_ctrl.sv
module trace_ptr_ctrl
  import trace_ptr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          traceEn,
  input  logic          wrReq,
  input  logic          rdReq,
  input  logic [1:0]    thrSel,
  output ctlStrobes_t   stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [PW-1:0] occ,
  output logic          irq
);

  localparam logic [PW-1:0] LVL_HALF = PW'(DEPTH / 2);
  localparam logic [PW-1:0] LVL_3Q   = PW'((3 * DEPTH) / 4);
  localparam logic [PW-1:0] LVL_FULL = PW'(DEPTH);

  // pointers carry one extra wrap bit so full and empty differ
  logic [PW-1:0] wrPtr, rdPtr, occNext, level;
  logic traceEnQ, pendDisc, rdPendQ, highNext, lowEmptyQ;
  logic newTrace, full, empty, wrAccept, wrDrop, rdWant, rdServe, advance, irqNext;

  assign occ   = wrPtr - rdPtr;
  assign full  = (occ == LVL_FULL);
  assign empty = (occ == '0);

  assign newTrace = traceEn & ~traceEnQ;
  assign wrAccept = traceEn & wrReq & ~full & ~newTrace;
  assign wrDrop   = traceEn & wrReq & full & ~newTrace;
  assign rdWant   = rdReq | rdPendQ;
  assign rdServe  = rdWant & ~wrAccept & ~newTrace;
  // the pointer moves on the high half, unless the low half saw an empty store
  assign advance  = rdServe & highNext & ~lowEmptyQ;
  assign occNext  = occ + PW'(wrAccept) - PW'(advance);

  always_comb begin
    unique case (thrSel)
      THR_HALF: level = LVL_HALF;
      THR_3Q:   level = LVL_3Q;
      THR_FULL: level = LVL_FULL;
      default:  level = '0;
    endcase
  end

  // only a write can raise occupancy, so equality after a write is the upward crossing
  assign irqNext = (thrSel != THR_OFF) & wrAccept & (occNext == level);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      traceEnQ  <= 1'b0;
      pendDisc  <= 1'b0;
      rdPendQ   <= 1'b0;
      highNext  <= 1'b0;
      lowEmptyQ <= 1'b0;
      irq       <= 1'b0;
    end else begin
      traceEnQ <= traceEn;
      irq      <= irqNext;
      if (newTrace) begin
        wrPtr     <= '0;
        rdPtr     <= '0;
        pendDisc  <= 1'b0;
        rdPendQ   <= 1'b0;
        highNext  <= 1'b0;
        lowEmptyQ <= 1'b0;
      end else begin
        if (wrAccept) begin
          wrPtr    <= wrPtr + 1'b1;
          pendDisc <= 1'b0;
        end else if (wrDrop) begin
          pendDisc <= 1'b1;
        end
        if (advance) rdPtr <= rdPtr + 1'b1;
        rdPendQ <= rdWant & ~rdServe;
        if (rdServe) begin
          highNext <= ~highNext;
          if (!highNext) lowEmptyQ <= empty;
        end
      end
    end
  end

  assign stb.wrEn      = wrAccept;
  assign stb.entryDisc = pendDisc;
  assign stb.rdEn      = rdServe;
  assign stb.rdHigh    = highNext;
  assign stb.rdHit     = highNext ? ~lowEmptyQ : ~empty;

  assign wrAddr = wrPtr[AW-1:0];
  assign rdAddr = rdPtr[AW-1:0];

endmodule

// File: rtl/trace_ptr_dpath.sv
module trace_ptr_dpath
  import trace_ptr_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int PAYLOAD_W = 67,
  parameter int REG_W     = 64,
  localparam int AW       = $clog2(DEPTH),
  localparam int TOP_W    = PAYLOAD_W - REG_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          stb,
  input  logic [AW-1:0]        wrAddr,
  input  logic [AW-1:0]        rdAddr,
  input  logic [PAYLOAD_W-1:0] wrData,
  output logic [REG_W-1:0]     rdData,
  output logic                 rdValid
);

  // stored entry: discontinuity bit above the payload; valid is derived at read time
  logic [PAYLOAD_W:0] mem [DEPTH];
  logic [PAYLOAD_W:0] entry;
  logic [REG_W-1:0]   loWord, hiWord;

  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[wrAddr] <= {stb.entryDisc, wrData};
  end

  assign entry  = mem[rdAddr];
  assign loWord = stb.rdHit ? entry[REG_W-1:0] : '0;

  always_comb begin
    hiWord = '0;
    hiWord[TOP_W-1:0] = stb.rdHit ? entry[PAYLOAD_W-1:REG_W] : '0;
    hiWord[TOP_W]     = stb.rdHit;
    hiWord[TOP_W+1]   = stb.rdHit ? entry[PAYLOAD_W] : stb.entryDisc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rdEn;
      if (stb.rdEn) rdData <= stb.rdHigh ? hiWord : loWord;
    end
  end

endmodule

// File: rtl/trace_ptr_unit.sv
module trace_ptr_unit
  import trace_ptr_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int PAYLOAD_W = 67,
  parameter int REG_W     = 64,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = AW + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 traceEn,
  input  logic                 wrReq,
  input  logic [PAYLOAD_W-1:0] wrData,
  input  logic                 rdReq,
  output logic [REG_W-1:0]     rdData,
  output logic                 rdValid,
  input  logic [1:0]           thrSel,
  output logic                 irq
);

  ctlStrobes_t   stb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [PW-1:0] occ;

  trace_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .wrReq(wrReq), .rdReq(rdReq),
    .thrSel(thrSel), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr), .occ(occ), .irq(irq)
  );

  trace_ptr_dpath #(.DEPTH(DEPTH), .PAYLOAD_W(PAYLOAD_W), .REG_W(REG_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/trace_ptr_checker.sv
module trace_ptr_checker #(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic [PW-1:0] occ,
  input logic          wrEn,
  input logic          rdEn,
  input logic          rdValid,
  input logic          irq
);

  a_r3_occ_bound: assert property (@(posedge clk) disable iff (!rstN)
    occ <= PW'(DEPTH));

  a_r3_no_write_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (occ == PW'(DEPTH)) |-> !wrEn);

  a_r2_write_advances: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (occ == $past(occ) + 1'b1));

  a_r8_single_port: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && rdEn));

  a_r8_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

endmodule

bind trace_ptr_unit trace_ptr_checker #(.DEPTH(DEPTH)) u_checker (
  .clk(clk), .rstN(rstN), .occ(occ), .wrEn(stb.wrEn), .rdEn(stb.rdEn),
  .rdValid(rdValid), .irq(irq)
);

// File: tb/test_trace_ptr_unit.sv
`timescale 1ns/1ps
module test_trace_ptr_unit;

  localparam int DEPTH = 16;
  localparam int PLW   = 67;
  localparam int RW    = 64;

  logic clk = 1'b0, rstN = 1'b0, traceEn = 1'b0, wrReq = 1'b0, rdReq = 1'b0, irq, rdValid;
  logic [PLW-1:0] wrData = '0;
  logic [RW-1:0]  rdData;
  logic [1:0]     thrSel = 2'd0;

  trace_ptr_unit #(.DEPTH(DEPTH), .PAYLOAD_W(PLW), .REG_W(RW)) i_trace_ptr_unit (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .wrReq(wrReq), .wrData(wrData),
    .rdReq(rdReq), .rdData(rdData), .rdValid(rdValid), .thrSel(thrSel), .irq(irq)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, pushCnt = 0, popCnt = 0;
  logic [RW-1:0] expQ[$];
  string         tagQ[$];
  logic [PLW:0]  modelQ[$];   // {disc, payload}
  bit pendM = 0, lowEmptyM = 0;

  task automatic check(input bit ok, input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [PLW-1:0] pay(input int i);
    return {3'(i), 32'(i * 7 + 1), 32'(~i)};
  endfunction

  function automatic int levelOf(input logic [1:0] s);
    case (s)
      2'd1: return DEPTH / 2;
      2'd2: return (3 * DEPTH) / 4;
      2'd3: return DEPTH;
      default: return -1;
    endcase
  endfunction

  // monitor: compares each returned word with the scoreboard head
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) check(1'b0, "R8 unexpected rdValid", rdData, '0);
      else begin
        automatic logic [RW-1:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(rdData === e, t, rdData, e);
      end
      popCnt++;
    end
  end

  task automatic waitAnswers();
    while (popCnt < pushCnt) @(negedge clk);
  endtask

  function automatic logic [RW-1:0] lowExp();
    if (modelQ.size() == 0) begin lowEmptyM = 1; return '0; end
    lowEmptyM = 0;
    return modelQ[0][RW-1:0];
  endfunction

  task automatic readLow(input string tag);
    expQ.push_back(lowExp()); tagQ.push_back(tag); pushCnt++;
    @(negedge clk) rdReq = 1'b1;
    @(negedge clk) rdReq = 1'b0;
    waitAnswers();
  endtask

  task automatic readHigh(input string tag);
    logic [RW-1:0] e = '0;
    if (lowEmptyM) e[4] = pendM;
    else begin
      automatic logic [PLW:0] h = modelQ.pop_front();
      e[2:0] = h[PLW-1:RW]; e[3] = 1'b1; e[4] = h[PLW];
    end
    expQ.push_back(e); tagQ.push_back(tag); pushCnt++;
    @(negedge clk) rdReq = 1'b1;
    @(negedge clk) rdReq = 1'b0;
    waitAnswers();
  endtask

  task automatic readEntry(input string tag);
    readLow({tag, " low word"});
    readHigh({tag, " high word/status"});
  endtask

  task automatic modelWrite(input logic [PLW-1:0] d, output bit acc);
    acc = 0;
    if (traceEn) begin
      if (modelQ.size() < DEPTH) begin modelQ.push_back({pendM, d}); pendM = 0; acc = 1; end
      else pendM = 1;
    end
  endtask

  task automatic wr(input logic [PLW-1:0] d, input string tag);
    bit acc; bit expIrq;
    @(negedge clk) begin wrReq = 1'b1; wrData = d; end
    @(negedge clk) wrReq = 1'b0;
    modelWrite(d, acc);
    expIrq = acc && (modelQ.size() == levelOf(thrSel));
    check(irq === expIrq, {tag, " irq"}, RW'(irq), RW'(expIrq));
  endtask

  task automatic setEn(input bit v);
    @(negedge clk) traceEn = v;
    if (v) begin modelQ.delete(); pendM = 0; lowEmptyM = 0; end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irq === 1'b0 && rdValid === 1'b0, "R1 reset outputs", RW'({irq, rdValid}), '0);
    rstN = 1'b1;
    setEn(1);

    // R5: empty store reads not-valid
    readEntry("R5 empty read");

    // R2 R6 R7: in-order readback of a few entries
    for (int i = 0; i < 3; i++) wr(pay(i), "R2 write");
    for (int i = 0; i < 3; i++) readEntry("R7 R6 in-order entry");

    // R9 at half level, R3 drops while full
    thrSel = 2'd1;
    for (int i = 10; i < 10 + DEPTH; i++) wr(pay(i), "R9 fill half level");
    wr(pay(90), "R3 dropped write");
    wr(pay(91), "R3 dropped write");
    readEntry("R3 oldest entry kept");
    // R9 relative: full level reached again after one read; R4 discontinuity mark
    thrSel = 2'd3;
    wr(pay(92), "R9 full level relative");
    thrSel = 2'd0;
    for (int i = 0; i < DEPTH; i++) readEntry("R4 drain with discontinuity");
    readEntry("R5 empty after drain");

    // R5 status 2: drop pending while empty
    for (int i = 0; i < DEPTH; i++) wr(pay(40 + i), "R3 refill");
    wr(pay(99), "R3 dropped write");
    for (int i = 0; i < DEPTH; i++) readEntry("R2 drain");
    readEntry("R5 empty with pending discontinuity");
    wr(pay(100), "R4 write after gap");
    readEntry("R4 status 3 entry");

    // R10: writes ignored while disabled, reads still drain
    wr(pay(101), "R10 write before disable");
    setEn(0);
    wr(pay(102), "R10 ignored write");
    wr(pay(103), "R10 ignored write");
    readEntry("R10 held entry");
    readEntry("R10 nothing else stored");

    // R1: restart discards held entries
    setEn(1);
    wr(pay(110), "R1 write before restart");
    wr(pay(111), "R1 write before restart");
    setEn(0);
    setEn(1);
    readEntry("R1 empty after restart");
    wr(pay(112), "R1 write after restart");
    readEntry("R1 entry after restart");

    // R8: read colliding with a write is deferred one cycle
    @(negedge clk) begin wrReq = 1'b1; rdReq = 1'b1; wrData = pay(120); end
    begin
      bit acc;
      modelWrite(pay(120), acc);
    end
    expQ.push_back(lowExp()); tagQ.push_back("R8 deferred read low word"); pushCnt++;
    @(negedge clk) begin wrReq = 1'b0; rdReq = 1'b0; end
    check(rdValid === 1'b0, "R8 no answer in write cycle", RW'(rdValid), '0);
    waitAnswers();
    readHigh("R8 deferred entry high word");

    // R5: low word on empty store, then a write, then the high word
    readLow("R5 low word on empty");
    wr(pay(130), "R5 write between halves");
    readHigh("R5 high word stays not-valid");
    readEntry("R5 entry still available");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule